// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block turns five reset causes of a network controller into separate reset lines for five logic domains. Two causes are chip-level hard resets: a power-on input and an external active-low pin. Two are register-level PHY reset requests: a bit in a power-management control register and a self-clearing bit in the PHY control register. The fifth cause is a software reset strobe. The five domains are the host bus interface, the MAC, the PHY, the general registers, and a retained register group that only the hard resets touch.

Each domain reset is asserted at once, and the hard resets assert it asynchronously. It is held for a parameterised minimum time and then released through a two-flop stage. After a hard reset or a software reset, the block asks an external configuration loader to reload its settings. It then shows a busy flag until that loader signals done. While the flag is set, host writes to the guarded registers are refused and recorded in a sticky error flag. Configuration straps are captured only while the retained domain is in reset.

The PHY request bits read back as set until the PHY reset pulse has ended, and then clear themselves. Data transfer is enabled only when the PHY is out of reset, no PHY request is pending and the link is up.

Top module: `rst_merge_seq`

## Requirements
- R1: While `por_n` or `ext_rst_n` is low, all five domain resets are low without waiting for a clock edge, and `cfg_busy` is high.
- R2: After the last hard reset input goes high, each domain reset goes high on the (HOLD_CYC+2)-th rising clock edge.
- R3: A `sw_rst_wr` pulse sampled at an edge drives the host, MAC, PHY and general domain resets low after that edge, for exactly HOLD_CYC+2 cycles. `keep_rst_n` stays high.
- R4: A `pwr_phy_wr` or `phy_ctl_wr` pulse drives only `phy_rst_n` low, for HOLD_CYC+2 cycles. The host, MAC, general and retained domains and `cfg_busy` are unaffected.
- R5: A PHY request bit reads 1 from the edge that samples its write until the edge after `phy_rst_n` rises. It is then 0, which makes it HOLD_CYC+3 cycles high.
- R6: After a hard or software reset, `cfg_busy` is 1. `cfg_req` rises only after `gen_rst_n` is high. Both `cfg_req` and `cfg_busy` drop after the edge that samples `cfg_done` high while `cfg_req` is high.
- R7: `guard_ok` equals `guard_wr` when `cfg_busy` is 0 and is 0 when `cfg_busy` is 1. A `guard_wr` sampled while busy sets `guard_err`, which stays set until a hard or software reset clears it.
- R8: `straps_q` takes the value of `straps_in` while the retained domain is in reset. A later software reset or a change of `straps_in` leaves it unchanged.
- R9: `xfer_en` is 1 exactly when `phy_rst_n` is 1, both PHY request bits are 0 and `link_up` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low |
| sw_rst_wr | input | 1 | Software reset strobe |
| pwr_phy_wr | input | 1 | Write 1 to the power-management PHY reset bit |
| phy_ctl_wr | input | 1 | Write 1 to the PHY control reset bit |
| cfg_done | input | 1 | Configuration loader finished |
| link_up | input | 1 | PHY link status |
| guard_wr | input | 1 | Host write to a guarded register |
| straps_in | input | STRAP_W | Configuration strap pins |
| host_rst_n | output | 1 | Host bus domain reset, active low |
| mac_rst_n | output | 1 | MAC domain reset, active low |
| phy_rst_n | output | 1 | PHY domain reset, active low |
| gen_rst_n | output | 1 | General register domain reset, active low |
| keep_rst_n | output | 1 | Retained register domain reset, active low |
| pwr_phy_bit | output | 1 | Readback of the power-management PHY reset bit |
| phy_ctl_bit | output | 1 | Readback of the PHY control reset bit |
| cfg_req | output | 1 | Configuration reload request |
| cfg_busy | output | 1 | Reload in progress |
| guard_ok | output | 1 | Guarded write accepted |
| guard_err | output | 1 | Sticky refused-write flag |
| straps_q | output | STRAP_W | Latched straps |
| xfer_en | output | 1 | Data transfer permitted |

## Verification
The bench applies each of the five causes in turn: power-on, external pin, software strobe and each PHY request bit. It counts the low cycles of every domain reset. The resulting per-domain count vector separates the hard-reset release timing, the software mask (retained domain spared) and the PHY-only mask. Guarded writes are tried both while a reload is pending and after it ends, which distinguishes refusal from acceptance and checks that the error flag is sticky. Strap values are changed between resets to show which resets capture them. `link_up` is swept while the PHY is both idle and in reset to test the transfer gate.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
   localparam int unsigned NDOM     = 5;
   localparam int unsigned DOM_HOST = 0;
   localparam int unsigned DOM_MAC  = 1;
   localparam int unsigned DOM_PHY  = 2;
   localparam int unsigned DOM_GEN  = 3;
   localparam int unsigned DOM_KEEP = 4;

   // software reset reaches every domain except the retained one
   function automatic logic sw_hits(int unsigned d);
      return d != DOM_KEEP;
   endfunction

   // PHY reset requests reach the PHY domain only
   function automatic logic phy_hits(int unsigned d);
      return d == DOM_PHY;
   endfunction
endpackage

// File: rtl/rst_stretch.sv
module rst_stretch #(
   parameter int unsigned HOLD_CYC = 4
) (
   input  logic clk,
   input  logic arst_n,
   input  logic trig,
   output logic rst_n
);
   localparam int unsigned CW = $clog2(HOLD_CYC + 1);
   localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("HOLD_CYC must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic          s1, s2, idle;

   assign idle  = (cnt == '0) && !trig;
   assign rst_n = s2;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt <= HOLD_V;
         s1  <= 1'b0;
         s2  <= 1'b0;
      end else begin
         if (trig)
            cnt <= HOLD_V;
         else if (cnt != '0)
            cnt <= cnt - CW'(1);
         s1 <= idle;
         s2 <= s1 & !trig;
      end
   end

   // R3/R4: a synchronous trigger pulls the reset low at the next edge
   p_trig_asserts_r3 : assert property (@(posedge clk) disable iff (!arst_n)
      trig |=> !rst_n);

   // R2: release only comes after the internal stage was already set
   p_release_staged_r2 : assert property (@(posedge clk) disable iff (!arst_n)
      $rose(rst_n) |-> $past(s1));
endmodule

// File: rtl/cfg_reload_ctl.sv
module cfg_reload_ctl (
   input  logic clk,
   input  logic arst_n,
   input  logic restart,
   input  logic dom_ready,
   input  logic done,
   output logic req,
   output logic busy
);
   typedef enum logic [1:0] {CR_IDLE, CR_WAIT, CR_REQ} cr_e;
   cr_e st;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)
         st <= CR_WAIT;
      else if (restart)
         st <= CR_WAIT;
      else begin
         case (st)
            CR_WAIT: if (dom_ready) st <= CR_REQ;
            CR_REQ:  if (done)      st <= CR_IDLE;
            default: st <= st;
         endcase
      end
   end

   assign req  = (st == CR_REQ);
   assign busy = (st != CR_IDLE);

   // R6: busy only ends after the loader reported done
   p_busy_end_r6 : assert property (@(posedge clk) disable iff (!arst_n)
      $fell(busy) |-> $past(done));

   // R6: no request while the general domain is still held
   p_req_after_ready_r6 : assert property (@(posedge clk) disable iff (!arst_n)
      !dom_ready |=> !req);
endmodule

// File: rtl/rst_merge_seq.sv
module rst_merge_seq #(
   parameter int unsigned HOLD_CYC = 4,
   parameter int unsigned STRAP_W  = 4
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               ext_rst_n,
   input  logic               sw_rst_wr,
   input  logic               pwr_phy_wr,
   input  logic               phy_ctl_wr,
   input  logic               cfg_done,
   input  logic               link_up,
   input  logic               guard_wr,
   input  logic [STRAP_W-1:0] straps_in,
   output logic               host_rst_n,
   output logic               mac_rst_n,
   output logic               phy_rst_n,
   output logic               gen_rst_n,
   output logic               keep_rst_n,
   output logic               pwr_phy_bit,
   output logic               phy_ctl_bit,
   output logic               cfg_req,
   output logic               cfg_busy,
   output logic               guard_ok,
   output logic               guard_err,
   output logic [STRAP_W-1:0] straps_q,
   output logic               xfer_en
);
   import rstseq_pkg::*;

   if (STRAP_W < 1) begin : g_bad_strap
      $error("STRAP_W must be at least 1");
   end

   logic            hard_n, sw_go, phy_go, phy_q, phy_rel;
   logic [NDOM-1:0] dom_n;

   assign hard_n = por_n & ext_rst_n;
   assign sw_go  = sw_rst_wr;
   assign phy_go = (pwr_phy_wr & ~pwr_phy_bit) | (phy_ctl_wr & ~phy_ctl_bit);

   for (genvar d = 0; d < NDOM; d++) begin : g_dom
      localparam logic SWH  = sw_hits(d);
      localparam logic PHYH = phy_hits(d);
      logic trig;
      assign trig = (SWH & sw_go) | (PHYH & phy_go);
      rst_stretch #(.HOLD_CYC(HOLD_CYC)) u_str (
         .clk   (clk),
         .arst_n(hard_n),
         .trig  (trig),
         .rst_n (dom_n[d])
      );
   end

   assign host_rst_n = dom_n[DOM_HOST];
   assign mac_rst_n  = dom_n[DOM_MAC];
   assign phy_rst_n  = dom_n[DOM_PHY];
   assign gen_rst_n  = dom_n[DOM_GEN];
   assign keep_rst_n = dom_n[DOM_KEEP];

   // PHY request bits clear themselves one edge after the PHY domain release
   always_ff @(posedge clk or negedge hard_n) begin
      if (!hard_n) begin
         phy_q       <= 1'b0;
         pwr_phy_bit <= 1'b0;
         phy_ctl_bit <= 1'b0;
      end else begin
         phy_q <= dom_n[DOM_PHY];
         if (pwr_phy_wr)   pwr_phy_bit <= 1'b1;
         else if (phy_rel) pwr_phy_bit <= 1'b0;
         if (phy_ctl_wr)   phy_ctl_bit <= 1'b1;
         else if (phy_rel) phy_ctl_bit <= 1'b0;
      end
   end
   assign phy_rel = dom_n[DOM_PHY] & ~phy_q;

   cfg_reload_ctl u_cfg (
      .clk      (clk),
      .arst_n   (hard_n),
      .restart  (sw_go),
      .dom_ready(dom_n[DOM_GEN]),
      .done     (cfg_done),
      .req      (cfg_req),
      .busy     (cfg_busy)
   );

   assign guard_ok = guard_wr & ~cfg_busy;

   always_ff @(posedge clk or negedge hard_n) begin
      if (!hard_n)                  guard_err <= 1'b0;
      else if (sw_go)               guard_err <= 1'b0;
      else if (guard_wr & cfg_busy) guard_err <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!dom_n[DOM_KEEP]) straps_q <= straps_in;
   end

   assign xfer_en = dom_n[DOM_PHY] & ~pwr_phy_bit & ~phy_ctl_bit & link_up;

   // R4: the MAC domain only falls on a software reset
   p_mac_sw_only_r4 : assert property (@(posedge clk) disable iff (!hard_n)
      $fell(mac_rst_n) |-> $past(sw_go));

   // R5: a request bit clears only once the PHY domain is out of reset
   p_bits_clear_r5 : assert property (@(posedge clk) disable iff (!hard_n)
      ($fell(pwr_phy_bit) || $fell(phy_ctl_bit)) |-> phy_rst_n);

   // R7: a refused write leaves the error flag set
   p_err_set_r7 : assert property (@(posedge clk) disable iff (!hard_n)
      (guard_wr && cfg_busy && !sw_go) |=> guard_err);

   // R3: software reset never touches the retained domain
   p_keep_sw_r3 : assert property (@(posedge clk) disable iff (!hard_n)
      (sw_go && keep_rst_n) |=> keep_rst_n);
endmodule

// File: tb/test_rst_merge_seq.sv
module test_rst_merge_seq;
   localparam int unsigned HOLD = 3;
   localparam int unsigned SW   = 4;

   logic clk = 1'b0;
   logic por_n = 1'b0, ext_rst_n = 1'b1, sw_rst_wr = 1'b0;
   logic pwr_phy_wr = 1'b0, phy_ctl_wr = 1'b0, cfg_done = 1'b0;
   logic link_up = 1'b0, guard_wr = 1'b0;
   logic [SW-1:0] straps_in = 4'hA;
   logic host_rst_n, mac_rst_n, phy_rst_n, gen_rst_n, keep_rst_n;
   logic pwr_phy_bit, phy_ctl_bit, cfg_req, cfg_busy, guard_ok, guard_err, xfer_en;
   logic [SW-1:0] straps_q;

   int n_run = 0, n_fail = 0;
   int lo[5];
   int pb, cb;
   logic [4:0] dom;

   always #10 clk = ~clk;

   rst_merge_seq #(.HOLD_CYC(HOLD), .STRAP_W(SW)) i_rst_merge_seq (
      .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .sw_rst_wr(sw_rst_wr),
      .pwr_phy_wr(pwr_phy_wr), .phy_ctl_wr(phy_ctl_wr), .cfg_done(cfg_done),
      .link_up(link_up), .guard_wr(guard_wr), .straps_in(straps_in),
      .host_rst_n(host_rst_n), .mac_rst_n(mac_rst_n), .phy_rst_n(phy_rst_n),
      .gen_rst_n(gen_rst_n), .keep_rst_n(keep_rst_n), .pwr_phy_bit(pwr_phy_bit),
      .phy_ctl_bit(phy_ctl_bit), .cfg_req(cfg_req), .cfg_busy(cfg_busy),
      .guard_ok(guard_ok), .guard_err(guard_err), .straps_q(straps_q),
      .xfer_en(xfer_en));

   assign dom = {keep_rst_n, gen_rst_n, phy_rst_n, mac_rst_n, host_rst_n};

   task automatic chk(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // kind: 0 none, 1 software, 2 power-management bit, 3 PHY control bit
   task automatic pulse_measure(int kind);
      for (int d = 0; d < 5; d++) lo[d] = 0;
      pb = 0; cb = 0;
      sw_rst_wr  = (kind == 1);
      pwr_phy_wr = (kind == 2);
      phy_ctl_wr = (kind == 3);
      for (int i = 0; i < 20; i++) begin
         @(posedge clk); @(negedge clk);
         if (i == 0) begin sw_rst_wr = 0; pwr_phy_wr = 0; phy_ctl_wr = 0; end
         for (int d = 0; d < 5; d++) if (!dom[d]) lo[d]++;
         if (pwr_phy_bit) pb++;
         if (phy_ctl_bit) cb++;
      end
   endtask

   task automatic finish_reload(string req);
      int w;
      w = 0;
      while (!cfg_req && w < 40) begin @(negedge clk); w++; end
      chk({req, " req seen"}, cfg_req, 1);
      cfg_done = 1;
      @(negedge clk);
      cfg_done = 0;
      chk({req, " busy drops"}, cfg_busy, 0);
      chk({req, " req drops"}, cfg_req, 0);
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 power-on
      chk("R1 domains low under por", dom, 0);
      chk("R1 busy under por", cfg_busy, 1);
      por_n = 1;
      pulse_measure(0);
      // R2 release timing: low samples after release = HOLD+1
      for (int d = 0; d < 5; d++) chk("R2 hard release", lo[d], HOLD + 1);
      chk("R6 busy after por", cfg_busy, 1);
      chk("R8 straps captured on por", straps_q, 4'hA);
      straps_in = 4'h5;
      // R7 while busy
      guard_wr = 1; #1;
      chk("R7 refused while busy", guard_ok, 0);
      @(negedge clk); guard_wr = 0; #1;
      chk("R7 err set", guard_err, 1);
      finish_reload("R6 after por");
      guard_wr = 1; #1;
      chk("R7 accepted when idle", guard_ok, 1);
      @(negedge clk); guard_wr = 0;
      chk("R7 err sticky", guard_err, 1);

      // R3 software reset
      pulse_measure(1);
      for (int d = 0; d < 4; d++) chk("R3 sw domains", lo[d], HOLD + 2);
      chk("R3 keep spared", lo[4], 0);
      chk("R7 err cleared by sw", guard_err, 0);
      chk("R6 busy after sw", cfg_busy, 1);
      chk("R8 straps kept over sw", straps_q, 4'hA);
      finish_reload("R6 after sw");

      // R4/R5 PHY request bits
      for (int k = 2; k <= 3; k++) begin
         pulse_measure(k);
         chk("R4 phy low", lo[2], HOLD + 2);
         chk("R4 host spared", lo[0], 0);
         chk("R4 mac spared", lo[1], 0);
         chk("R4 gen spared", lo[3], 0);
         chk("R4 keep spared", lo[4], 0);
         chk("R4 busy unaffected", cfg_busy, 0);
         chk("R5 bit high cycles", (k == 2) ? pb : cb, HOLD + 3);
         chk("R5 other bit idle", (k == 2) ? cb : pb, 0);
      end

      // R9 transfer gate sweep
      for (int l = 0; l < 2; l++) begin
         link_up = l[0]; #1;
         chk("R9 idle gate", xfer_en, l);
      end
      pwr_phy_wr = 1;
      for (int i = 0; i < HOLD + 3; i++) begin
         @(negedge clk); pwr_phy_wr = 0;
         chk("R9 gate during phy reset", xfer_en, 0);
      end
      @(negedge clk);
      chk("R9 gate after phy reset", xfer_en, 1);
      link_up = 0;

      // R1 external pin, asynchronous
      @(negedge clk); #5;
      ext_rst_n = 0; #1;
      chk("R1 domains low under ext pin", dom, 0);
      chk("R1 busy under ext pin", cfg_busy, 1);
      @(negedge clk); @(negedge clk);
      ext_rst_n = 1;
      pulse_measure(0);
      for (int d = 0; d < 5; d++) chk("R2 ext release", lo[d], HOLD + 1);
      chk("R8 straps captured on ext", straps_q, 4'h5);
      finish_reload("R6 after ext");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule